// File: doc/BRIEF.md
# Multiplexed CPU Bus Controller

This block paces an externally clocked 8-bit microprocessor and moves all traffic with it over one shared 16-bit bus. It makes the processor's two quadrature clocks, E and Q, and lets the quarter-phase length change from one CPU cycle to the next. A 3-bit mode code, meant for an off-block 3-to-8 decoder, says what the shared bus carries on each clock. Within a CPU cycle the block first takes in the address, then the status byte. It then either returns a byte from its internal RAM model (read) or collects the byte the processor writes.

A spare slot near the end of each cycle serves one queued request. The request is either an update of the slow control latch (reset, halt and interrupt lines) or a trigger pulse to one of three auxiliary peripheral ports. The bus is split into `bus_i`, `bus_o` and `bus_oe_o` so that a pad ring or a test model can close the loop.

Top module: `cpu_bus_ctrl`

## Requirements
- R1: A CPU cycle is four quarters of L clocks each. `q_o` is high in quarters 0 and 1, and `e_o` is high in quarters 1 and 2, so Q leads E by one quarter.
- R2: L is taken from `quarter_len_i` on the last clock of the previous CPU cycle, and a value below 2 counts as 2. After reset, two clocks of quarter 3 (E and Q low) pass before Q first rises.
- R3: Quarter 0 shows mode 1 for its first L-1 clocks and mode 2 on its last clock. `addr_o` takes `bus_i` on the last mode-1 clock, and `status_o` takes `bus_i[15:8]` on the mode-2 clock. Status bit 0 (bus bit 8) is the read flag, with 1 meaning read.
- R4: In a read cycle the mode is 3 through quarters 1 and 2 and on the first clock of quarter 3. During that time `bus_o` is {8'h00, RAM byte at the captured address}.
- R5: In a write cycle the mode is 2 through quarters 1 and 2. On the last clock of quarter 2 (the E falling edge), `bus_i[7:0]` is written to RAM and `status_o` is sampled again. The first clock of quarter 3 is mode 0.
- R6: `bus_oe_o` is high exactly in modes 3 and 4. All other clocks that are not named in R3 to R8 are mode 0.
- R7: A pulse on `ctrl_upd_i` queues `ctrl_val_i`, and a later pulse replaces the queued value. The queued value is driven in mode 4 on the second clock of quarter 3, with `bus_o` set to {value, 8'h00}. `ctrl_o` takes the value at the end of that clock and holds it at all other times.
- R8: A pulse on `aux_req_i[k]` queues a trigger. It is served as mode 5+k in the quarter-3 service slot when no control update is queued, lowest k first, and one request is served per cycle.
- R9: `bus_i` is ignored outside modes 1 and 2, so `addr_o`, `status_o` and the RAM do not change then.
- R10: During reset the mode is 0, E, Q and `bus_oe_o` are low, `addr_o` and `status_o` are zero, and `ctrl_o` is CTRL_RST (8'h00).
- R11: The RAM holds 2^RAM_AW bytes (256 by default), indexed by the low RAM_AW address bits, so addresses that differ only above those bits alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| quarter_len_i | input | CNT_W | Requested clocks per quarter phase |
| mode_o | output | 3 | Bus mode code for the external decoder |
| e_o | output | 1 | CPU E clock |
| q_o | output | 1 | CPU Q clock |
| bus_i | input | 16 | Shared bus, value seen by the controller |
| bus_o | output | 16 | Shared bus, value driven by the controller |
| bus_oe_o | output | 1 | Controller drives the shared bus |
| ctrl_upd_i | input | 1 | Queue a slow-control latch update |
| ctrl_val_i | input | 8 | Value for the slow-control latch |
| aux_req_i | input | 3 | Queue a trigger for auxiliary port k |
| ctrl_o | output | 8 | Current slow-control latch contents |
| addr_o | output | 16 | Last captured CPU address |
| status_o | output | 8 | Last captured CPU status byte |

## Verification
The mode code, E, Q, the output enable and the driven bus are combinational functions of the phase counters. The bench therefore checks them half a clock after each edge, from its own quarter and clock count. A captured address or status is due one clock after its sampling clock, and is checked at the start of the next quarter. A RAM write made at the E falling edge becomes visible in the next read cycle's mode-3 drive. A served control update shows on `ctrl_o` on the clock after the service slot. The bench compares `ctrl_o` on every clock, so early or late changes are caught as well.

// File: rtl/cbc_pkg.sv
`timescale 1ns/1ps
package cbc_pkg;
  typedef enum logic [2:0] {
    M_IDLE = 3'd0,
    M_ADDR = 3'd1,
    M_STAT = 3'd2,
    M_DRV  = 3'd3,
    M_CTRL = 3'd4,
    M_AUX0 = 3'd5,
    M_AUX1 = 3'd6,
    M_AUX2 = 3'd7
  } mode_e;

  // quarter names follow the edge that opens them
  typedef enum logic [1:0] {
    QTR_QR = 2'd0,
    QTR_ER = 2'd1,
    QTR_QF = 2'd2,
    QTR_EF = 2'd3
  } qtr_e;

  localparam int unsigned BUS_W  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned N_AUX  = 3;
endpackage

// File: rtl/cbc_phase_gen.sv
`timescale 1ns/1ps
module cbc_phase_gen
  import cbc_pkg::*;
#(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned MIN_LEN = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] len_req_i,
  output qtr_e             qtr_o,
  output logic [CNT_W-1:0] sub_o,
  output logic [CNT_W-1:0] len_o,
  output logic             qtr_last_o,
  output logic             e_o,
  output logic             q_o
);
  localparam logic [CNT_W-1:0] LEN_FLOOR = CNT_W'(MIN_LEN);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  qtr_e             qtr_q;
  logic [CNT_W-1:0] sub_q, len_q, len_next;
  logic             qtr_last;

  assign len_next = (len_req_i < LEN_FLOOR) ? LEN_FLOOR : len_req_i;
  assign qtr_last = (sub_q == len_q - ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qtr_q <= QTR_EF;
      sub_q <= '0;
      len_q <= LEN_FLOOR;
    end else if (qtr_last) begin
      sub_q <= '0;
      qtr_q <= qtr_e'(qtr_q + 2'd1);
      if (qtr_q == QTR_EF) len_q <= len_next;
    end else begin
      sub_q <= sub_q + ONE;
    end
  end

  assign qtr_o      = qtr_q;
  assign sub_o      = sub_q;
  assign len_o      = len_q;
  assign qtr_last_o = qtr_last;
  assign q_o        = (qtr_q == QTR_QR) || (qtr_q == QTR_ER);
  assign e_o        = (qtr_q == QTR_ER) || (qtr_q == QTR_QF);

  a_r1_e_rises_under_q: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(e_o) |-> q_o);
  a_r1_q_falls_under_e: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(q_o) |-> e_o);
  a_r2_len_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_q >= LEN_FLOOR);
  a_r2_len_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(qtr_last && qtr_q == QTR_EF) |=> $stable(len_o));
endmodule

// File: rtl/cbc_slot_arb.sv
`timescale 1ns/1ps
module cbc_slot_arb #(
  parameter int unsigned CTRL_W   = 8,
  parameter int unsigned AUX_N    = 3,
  parameter logic [CTRL_W-1:0] CTRL_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_upd_i,
  input  logic [CTRL_W-1:0] ctrl_val_i,
  input  logic [AUX_N-1:0]  aux_req_i,
  input  logic              slot_i,
  output logic              grant_ctrl_o,
  output logic [AUX_N-1:0]  grant_aux_o,
  output logic [CTRL_W-1:0] ctrl_drive_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic              ctrl_pend_q;
  logic [CTRL_W-1:0] ctrl_val_q, ctrl_q;
  logic [AUX_N-1:0]  aux_pend_q, aux_pick;

  // lowest pending index wins
  assign aux_pick     = aux_pend_q & (~aux_pend_q + AUX_N'(1));
  assign grant_ctrl_o = slot_i && ctrl_pend_q;
  assign grant_aux_o  = (slot_i && !ctrl_pend_q) ? aux_pick : '0;
  assign ctrl_drive_o = ctrl_val_q;
  assign ctrl_o       = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_pend_q <= 1'b0;
      ctrl_val_q  <= '0;
      ctrl_q      <= CTRL_RST;
      aux_pend_q  <= '0;
    end else begin
      if (ctrl_upd_i) begin
        ctrl_pend_q <= 1'b1;
        ctrl_val_q  <= ctrl_val_i;
      end else if (grant_ctrl_o) begin
        ctrl_pend_q <= 1'b0;
      end
      if (grant_ctrl_o) ctrl_q <= ctrl_val_q;
      aux_pend_q <= (aux_pend_q & ~grant_aux_o) | aux_req_i;
    end
  end

  a_r8_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({grant_ctrl_o, grant_aux_o}));
  a_r8_grant_in_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|grant_aux_o) |-> slot_i);
  a_r7_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_ctrl_o |=> $stable(ctrl_o));
endmodule

// File: rtl/cbc_ram.sv
`timescale 1ns/1ps
module cbc_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/cpu_bus_ctrl.sv
`timescale 1ns/1ps
module cpu_bus_ctrl
  import cbc_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned RAM_AW   = 8,
  parameter logic [7:0]  CTRL_RST = 8'h00
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] quarter_len_i,
  output logic [2:0]       mode_o,
  output logic             e_o,
  output logic             q_o,
  input  logic [15:0]      bus_i,
  output logic [15:0]      bus_o,
  output logic             bus_oe_o,
  input  logic             ctrl_upd_i,
  input  logic [7:0]       ctrl_val_i,
  input  logic [2:0]       aux_req_i,
  output logic [7:0]       ctrl_o,
  output logic [15:0]      addr_o,
  output logic [7:0]       status_o
);
  localparam logic [CNT_W-1:0] TWO  = CNT_W'(2);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  qtr_e                qtr;
  logic [CNT_W-1:0]    sub, len;
  logic                qtr_last;
  logic                addr_cap, stat_cap, wr_end, slot, drv_rd;
  logic                rd_q;
  logic [BUS_W-1:0]    addr_q;
  logic [BYTE_W-1:0]   status_q, ram_rd, ctrl_drive;
  logic                grant_ctrl;
  logic [N_AUX-1:0]    grant_aux;
  mode_e               mode, slot_mode;

  cbc_phase_gen #(.CNT_W(CNT_W), .MIN_LEN(2)) u_phase (
    .clk_i, .rst_ni,
    .len_req_i (quarter_len_i),
    .qtr_o     (qtr),
    .sub_o     (sub),
    .len_o     (len),
    .qtr_last_o(qtr_last),
    .e_o, .q_o
  );

  assign slot     = (qtr == QTR_EF) && (sub == ONE);
  assign addr_cap = (qtr == QTR_QR) && (sub == len - TWO);
  assign stat_cap = (qtr == QTR_QR) && qtr_last;
  assign wr_end   = (qtr == QTR_QF) && qtr_last && !rd_q;
  assign drv_rd   = rd_q && ((qtr == QTR_ER) || (qtr == QTR_QF) ||
                             ((qtr == QTR_EF) && (sub == ZERO)));

  cbc_slot_arb #(.CTRL_W(BYTE_W), .AUX_N(N_AUX), .CTRL_RST(CTRL_RST)) u_arb (
    .clk_i, .rst_ni,
    .ctrl_upd_i, .ctrl_val_i, .aux_req_i,
    .slot_i      (slot),
    .grant_ctrl_o(grant_ctrl),
    .grant_aux_o (grant_aux),
    .ctrl_drive_o(ctrl_drive),
    .ctrl_o
  );

  cbc_ram #(.AW(RAM_AW), .DW(BYTE_W)) u_ram (
    .clk_i,
    .we_i   (wr_end),
    .addr_i (addr_q[RAM_AW-1:0]),
    .wdata_i(bus_i[BYTE_W-1:0]),
    .rdata_o(ram_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      status_q <= '0;
      rd_q     <= 1'b0;
    end else begin
      if (addr_cap) addr_q <= bus_i;
      if (stat_cap) rd_q <= bus_i[BYTE_W];
      if (stat_cap || wr_end) status_q <= bus_i[BUS_W-1:BYTE_W];
    end
  end

  always_comb begin
    slot_mode = M_IDLE;
    if (grant_ctrl)        slot_mode = M_CTRL;
    else if (grant_aux[0]) slot_mode = M_AUX0;
    else if (grant_aux[1]) slot_mode = M_AUX1;
    else if (grant_aux[2]) slot_mode = M_AUX2;
  end

  always_comb begin
    unique case (qtr)
      QTR_QR:  mode = qtr_last ? M_STAT : M_ADDR;
      QTR_ER,
      QTR_QF:  mode = rd_q ? M_DRV : M_STAT;
      default: begin
        if (sub == ZERO) mode = rd_q ? M_DRV : M_IDLE;
        else if (slot)   mode = slot_mode;
        else             mode = M_IDLE;
      end
    endcase
  end

  assign mode_o   = mode;
  assign bus_oe_o = drv_rd || grant_ctrl;
  assign bus_o    = grant_ctrl ? {ctrl_drive, {BYTE_W{1'b0}}} :
                    drv_rd     ? {{BYTE_W{1'b0}}, ram_rd} : '0;
  assign addr_o   = addr_q;
  assign status_o = status_q;

  a_r6_oe_only_drive_modes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> (mode_o == M_DRV || mode_o == M_CTRL));
  a_r6_drive_modes_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_DRV || mode_o == M_CTRL) |-> bus_oe_o);
  a_r5_write_at_e_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_end |=> $fell(e_o));
  a_r9_addr_from_y1_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(addr_o) |-> $past(mode_o) == M_ADDR);
  a_r4_drive_only_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_DRV) |-> status_o[0]);
endmodule

// File: tb/cpu_bus_ctrl_tb_top.sv
`timescale 1ns/1ps
module cpu_bus_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  quarter_len = 8'd2;
  logic [2:0]  mode;
  logic        e, q, oe;
  logic [15:0] bus_in, bus_out, addr;
  logic        ctrl_upd = 1'b0;
  logic [7:0]  ctrl_val = 8'h00;
  logic [2:0]  aux_req = 3'b000;
  logic [7:0]  ctrl, status;

  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_stat = 8'h00;
  logic [7:0]  cpu_data = 8'h00;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [7:0] mem [256];
  bit         exp_cpend = 1'b0;
  logic [7:0] exp_cval = 8'h00;
  logic [7:0] exp_ctrl = 8'h00;
  logic [2:0] exp_apend = 3'b000;

  always #2.5 clk = ~clk;

  // CPU model: answers only in address and status modes
  always_comb begin
    case (mode)
      3'd1:    bus_in = cpu_addr;
      3'd2:    bus_in = {cpu_stat, cpu_data};
      default: bus_in = 16'hC33C;
    endcase
  end

  cpu_bus_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .quarter_len_i(quarter_len),
    .mode_o(mode), .e_o(e), .q_o(q),
    .bus_i(bus_in), .bus_o(bus_out), .bus_oe_o(oe),
    .ctrl_upd_i(ctrl_upd), .ctrl_val_i(ctrl_val), .aux_req_i(aux_req),
    .ctrl_o(ctrl), .addr_o(addr), .status_o(status)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_cycle(input int req, input logic [15:0] a, input logic rd,
                           input logic [7:0] d, input logic [6:0] st,
                           input logic upd, input logic [7:0] uval,
                           input logic [2:0] aux, input logic [15:0] alias_x);
    int eff;
    int idx;
    logic [2:0] em;
    logic [15:0] pa;
    eff = (req < 2) ? 2 : req;
    pa  = a ^ alias_x;
    quarter_len = 8'(req);
    cpu_addr = (eff > 2) ? ~pa : pa;
    cpu_stat = {st, rd};
    cpu_data = d;
    idx = 0;
    for (int qt = 0; qt < 4; qt++) begin
      for (int s = 0; s < eff; s++) begin
        @(negedge clk);
        if (idx == 1) begin
          ctrl_upd = 1'b0;
          aux_req  = 3'b000;
        end
        if (qt == 0)      em = (s < eff - 1) ? 3'd1 : 3'd2;
        else if (qt < 3)  em = rd ? 3'd3 : 3'd2;
        else if (s == 0)  em = rd ? 3'd3 : 3'd0;
        else if (s == 1) begin
          if (exp_cpend)         em = 3'd4;
          else if (exp_apend[0]) em = 3'd5;
          else if (exp_apend[1]) em = 3'd6;
          else if (exp_apend[2]) em = 3'd7;
          else                   em = 3'd0;
        end else em = 3'd0;
        if (qt == 0)                chk("R3 mode", 32'(mode), 32'(em));
        else if (qt < 3)            chk(rd ? "R4 mode" : "R5 mode", 32'(mode), 32'(em));
        else if (s == 1 && em == 3'd4) chk("R7 slot mode", 32'(mode), 32'(em));
        else if (s == 1 && em != 3'd0) chk("R8 slot mode", 32'(mode), 32'(em));
        else                        chk("R6 mode", 32'(mode), 32'(em));
        chk("R1 e", 32'(e), 32'(qt == 1 || qt == 2));
        chk("R2 q", 32'(q), 32'(qt < 2));
        chk("R6 oe", 32'(oe), 32'(em == 3'd3 || em == 3'd4));
        chk("R7 ctrl hold", 32'(ctrl), 32'(exp_ctrl));
        if (em == 3'd3)
          chk(alias_x != 16'h0 ? "R11 alias read" : "R4 read data",
              32'(bus_out), 32'({8'h00, mem[pa[7:0]]}));
        if (em == 3'd4) begin
          chk("R7 drive", 32'(bus_out), 32'({exp_cval, 8'h00}));
          exp_ctrl  = exp_cval;
          exp_cpend = 1'b0;
        end else if (em >= 3'd5) begin
          exp_apend[em - 3'd5] = 1'b0;
        end
        if (qt == 1 && s == 0) begin
          chk("R3 addr", 32'(addr), 32'(pa));
          chk("R3 status", 32'(status), 32'({st, rd}));
          if (!rd) cpu_data = ~d;
        end
        if (qt == 2 && s == 0) cpu_data = d;
        if (qt == 2 && s == eff - 1 && !rd) mem[pa[7:0]] = d;
        if (qt == 3 && s == eff - 1) begin
          chk("R9 addr kept", 32'(addr), 32'(pa));
          chk("R9 status kept", 32'(status), 32'({st, rd}));
        end
        if (qt == 0 && s == 0) begin
          cpu_addr = pa;
          if (upd) begin
            ctrl_upd = 1'b1;
            ctrl_val = uval;
            exp_cpend = 1'b1;
            exp_cval  = uval;
          end
          aux_req = aux;
          exp_apend = exp_apend | aux;
        end
        idx++;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 mode", 32'(mode), 32'd0);
    chk("R10 e", 32'(e), 32'd0);
    chk("R10 q", 32'(q), 32'd0);
    chk("R10 oe", 32'(oe), 32'd0);
    chk("R10 ctrl", 32'(ctrl), 32'h00);
    chk("R10 addr", 32'(addr), 32'd0);
    chk("R10 status", 32'(status), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 idle after reset", 32'({mode, e, q}), 32'd0);
    // writes, sweeping quarter length requests 0..5
    for (int i = 0; i < 16; i++) begin
      logic [15:0] a;
      logic        u;
      logic [7:0]  uv;
      logic [2:0]  ax;
      a  = 16'(i * 16'h1000 + i * 17);
      u  = (i == 3) || (i == 6) || (i == 11);
      uv = 8'(i * 8'h1D + 8'h47);
      ax = (i == 5) ? 3'b110 : (i == 6) ? 3'b001 : (i == 7) ? 3'b111 : 3'b000;
      run_cycle(i % 6, a, 1'b0, 8'(i * 37 + 5), 7'(i * 3), u, uv, ax, 16'h0000);
    end
    // read back, some through aliased upper address bits
    for (int i = 0; i < 16; i++) begin
      logic [15:0] a;
      a = 16'(i * 16'h1000 + i * 17);
      run_cycle((i + 2) % 6, a, 1'b1, 8'hEE, 7'(i), i == 9, 8'h3C,
                (i == 2) ? 3'b100 : 3'b000, (i % 3 == 0) ? 16'hF300 : 16'h0000);
    end
    // overwrite one location, then read it
    run_cycle(3, 16'h0011, 1'b0, 8'h99, 7'h7F, 1'b0, 8'h00, 3'b000, 16'h0000);
    run_cycle(2, 16'h8811, 1'b1, 8'h00, 7'h01, 1'b0, 8'h00, 3'b000, 16'h0000);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule